// File: doc/BRIEF.md
# Count-down timer and random-number CSR bank

This block is a small bank of machine-mode control and status registers with three entries. A time register counts down by one on every clock and can only be changed by hardware. A compare register is read and written by software; when the time register reaches the compare value, the block raises a sticky timer-interrupt request. A 32-bit linear feedback shift register gives software a stream of pseudo-random values. Hardware can reseed it, and software can only read it.

Software reaches the bank through a simple CSR port: an address, write data and a write strobe, with read data returned combinationally in the same cycle. Hardware reseeds the random source through a separate load strobe and seed word. The interrupt request goes to the core's trap logic, which is not part of this block.

Top module: `tmr_rng_csr`

## Requirements
- R1: The time register (address 0x7C0) holds 0xFFFFFFFF during reset and decreases by exactly one on every clock after reset, wrapping from 0 to 0xFFFFFFFF.
- R2: A software write to the time address leaves the time register on its normal count-down path.
- R3: The compare register (address 0x7C1) resets to 0. A write strobe at that address loads the write data, which reads back from the next cycle on.
- R4: In any clock cycle where the time register equals the compare register and no compare write occurs, the interrupt output goes high from the next cycle on. It then stays high.
- R5: A write to the compare register drives the interrupt output low in the next cycle. This takes priority over a match in the same cycle.
- R6: The random register (address 0x7C2) resets to 0xB5C39A17. On every clock after reset without a seed load, its value s becomes {s[30:0], s[31]^s[21]^s[1]^s[0]}, which is the polynomial x^32+x^22+x^2+x+1.
- R7: A seed load takes priority over stepping. The loaded seed reads back in the next cycle.
- R8: A seed load of zero loads 0x00000001 instead, so the register never holds zero.
- R9: A software write to the random address leaves the random register on its normal stepping or seeding path.
- R10: A read of any 12-bit address other than the three mapped ones returns 0.
- R11: Read data follows the address in the same cycle and shows the register contents as of the last clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | 32 | CSR write data |
| csr_we | input | 1 | CSR write strobe |
| csr_rdata | output | 32 | CSR read data (combinational) |
| seed_ld | input | 1 | Hardware seed load strobe for the random register |
| seed_val | input | 32 | Seed value |
| timer_irq | output | 1 | Sticky timer-interrupt request |

## Verification
Every stored value can be read at the ports, so a wrong time, compare or random state shows up on the read port in the same cycle it exists. The bench reads the time and random registers after every clock, which places any count or feedback-tap error within one cycle. A wrong pending state shows on the interrupt output one cycle after the match or compare write that should have set or cleared it. A write that wrongly reaches a read-only register breaks the expected sequence at the next read.

// File: rtl/tmr_rng_pkg.sv
package tmr_rng_pkg;

    localparam int unsigned DATA_W = 32;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_TIME = 2'd1,
        SEL_CMP  = 2'd2,
        SEL_RAND = 2'd3
    } csr_sel_e;

    typedef struct packed {
        logic  wr_cmp;
        word_t data;
    } cmp_wr_t;

    typedef struct packed {
        logic  load;
        word_t value;
    } seed_req_t;

    // feedback taps for x^32 + x^22 + x^2 + x + 1 (bits 31, 21, 1, 0)
    localparam word_t RNG_TAPS = word_t'((64'd1 << 31) | (64'd1 << 21) | 64'd2 | 64'd1);

    function automatic word_t rng_step(input word_t s);
        return {s[DATA_W-2:0], ^(s & RNG_TAPS)};
    endfunction

    function automatic csr_sel_e csr_decode(input logic [11:0] a,
                                            input logic [11:0] a_time,
                                            input logic [11:0] a_cmp,
                                            input logic [11:0] a_rand);
        if (a == a_time)      return SEL_TIME;
        else if (a == a_cmp)  return SEL_CMP;
        else if (a == a_rand) return SEL_RAND;
        else                  return SEL_NONE;
    endfunction

endpackage

// File: rtl/tmr_rng_timer.sv
module tmr_rng_timer
    import tmr_rng_pkg::*;
#(
    parameter word_t TIME_INIT = '1
) (
    input  logic    clk,
    input  logic    rst,
    input  cmp_wr_t cmp_req,
    output word_t   time_val,
    output word_t   cmp_val,
    output logic    pend
);

    word_t time_q;
    word_t cmp_q;
    logic  pend_q;
    logic  hit;

    assign hit = (time_q == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q <= TIME_INIT;
            cmp_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            time_q <= time_q - word_t'(1);
            if (cmp_req.wr_cmp) begin
                cmp_q  <= cmp_req.data;
                pend_q <= 1'b0;
            end else if (hit) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign time_val = time_q;
    assign cmp_val  = cmp_q;
    assign pend     = pend_q;

    // R1
    time_dec_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> time_q == $past(time_q) - word_t'(1));

    // R5
    pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_req.wr_cmp |=> !pend_q);

    // R4
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !cmp_req.wr_cmp) |=> pend_q);

    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !cmp_req.wr_cmp) |=> pend_q);

    // R3
    cmp_load_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_req.wr_cmp |=> cmp_q == $past(cmp_req.data));

endmodule

// File: rtl/tmr_rng_lfsr.sv
module tmr_rng_lfsr
    import tmr_rng_pkg::*;
#(
    parameter word_t RESET_SEED = 32'hB5C3_9A17,
    parameter word_t ZERO_SUB   = 32'h0000_0001
) (
    input  logic      clk,
    input  logic      rst,
    input  seed_req_t seed,
    output word_t     rnd
);

    word_t state_q;
    word_t seed_eff;

    assign seed_eff = (seed.value == '0) ? ZERO_SUB : seed.value;

    always_ff @(posedge clk) begin
        if (rst)            state_q <= RESET_SEED;
        else if (seed.load) state_q <= seed_eff;
        else                state_q <= rng_step(state_q);
    end

    assign rnd = state_q;

    // R8
    rng_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> state_q != '0);

    // R7
    rng_seed_chk: assert property (@(posedge clk) disable iff (rst)
        (seed.load && seed.value != '0) |=> state_q == $past(seed.value));

    // R6
    rng_shift_chk: assert property (@(posedge clk) disable iff (rst)
        !seed.load |=> state_q[DATA_W-1:1] == $past(state_q[DATA_W-2:0]));

endmodule

// File: rtl/tmr_rng_rdmux.sv
module tmr_rng_rdmux
    import tmr_rng_pkg::*;
(
    input  csr_sel_e sel,
    input  word_t    time_val,
    input  word_t    cmp_val,
    input  word_t    rnd_val,
    output word_t    rdata
);

    always_comb begin
        unique case (sel)
            SEL_TIME: rdata = time_val;
            SEL_CMP:  rdata = cmp_val;
            SEL_RAND: rdata = rnd_val;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_rng_csr.sv
module tmr_rng_csr
    import tmr_rng_pkg::*;
#(
    parameter logic [11:0] ADDR_TIME = 12'h7C0,
    parameter logic [11:0] ADDR_CMP  = 12'h7C1,
    parameter logic [11:0] ADDR_RAND = 12'h7C2,
    parameter word_t       TIME_INIT = '1,
    parameter word_t       RNG_SEED0 = 32'hB5C3_9A17,
    parameter word_t       RNG_ZSUB  = 32'h0000_0001
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [11:0] csr_addr,
    input  logic [31:0] csr_wdata,
    input  logic        csr_we,
    output logic [31:0] csr_rdata,
    input  logic        seed_ld,
    input  logic [31:0] seed_val,
    output logic        timer_irq
);

    csr_sel_e  sel;
    cmp_wr_t   cmp_req;
    seed_req_t seed_req;
    word_t     time_w;
    word_t     cmp_w;
    word_t     rnd_w;

    assign sel            = csr_decode(csr_addr, ADDR_TIME, ADDR_CMP, ADDR_RAND);
    assign cmp_req.wr_cmp = csr_we && (sel == SEL_CMP);
    assign cmp_req.data   = csr_wdata;
    assign seed_req.load  = seed_ld;
    assign seed_req.value = seed_val;

    tmr_rng_timer #(.TIME_INIT(TIME_INIT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .cmp_req  (cmp_req),
        .time_val (time_w),
        .cmp_val  (cmp_w),
        .pend     (timer_irq)
    );

    tmr_rng_lfsr #(.RESET_SEED(RNG_SEED0), .ZERO_SUB(RNG_ZSUB)) u_lfsr (
        .clk  (clk),
        .rst  (rst),
        .seed (seed_req),
        .rnd  (rnd_w)
    );

    tmr_rng_rdmux u_rdmux (
        .sel      (sel),
        .time_val (time_w),
        .cmp_val  (cmp_w),
        .rnd_val  (rnd_w),
        .rdata    (csr_rdata)
    );

    // R2
    time_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_we && sel == SEL_TIME) |=> time_w == $past(time_w) - word_t'(1));

    // R9
    rand_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_we && sel == SEL_RAND && !seed_ld) |=> rnd_w == rng_step($past(rnd_w)));

endmodule

// File: tb/tmr_rng_csr_tb.sv
`timescale 1ns/1ps
module tmr_rng_csr_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_rdata;
    logic        seed_ld = 1'b0;
    logic [31:0] seed_val = '0;
    logic        timer_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_time, m_cmp, m_rnd;
    logic        m_pend;

    localparam logic [11:0] A_TIME = 12'h7C0;
    localparam logic [11:0] A_CMP  = 12'h7C1;
    localparam logic [11:0] A_RAND = 12'h7C2;

    always #2.5 clk = ~clk;

    tmr_rng_csr u_dut (
        .clk       (clk),
        .rst       (rst),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .csr_we    (csr_we),
        .csr_rdata (csr_rdata),
        .seed_ld   (seed_ld),
        .seed_val  (seed_val),
        .timer_irq (timer_irq)
    );

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: model follows the inputs held across the edge
    task automatic tick();
        logic cw;
        @(posedge clk);
        cw = csr_we && (csr_addr == A_CMP);
        if (rst) begin
            m_time = 32'hFFFF_FFFF; m_cmp = '0; m_pend = 1'b0; m_rnd = 32'hB5C3_9A17;
        end else begin
            m_pend = cw ? 1'b0 : (m_pend | (m_time == m_cmp));
            if (cw) m_cmp = csr_wdata;
            m_time = m_time - 32'd1;
            if (seed_ld) m_rnd = (seed_val == 0) ? 32'h1 : seed_val;
            else         m_rnd = nxt(m_rnd);
        end
        #1;
        csr_we = 1'b0; seed_ld = 1'b0;
    endtask

    task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        csr_addr = a;
        #0.5;
        chk(req, csr_rdata, exp);
    endtask

    task automatic look();
        rd("R1", A_TIME, m_time);
        rd("R6", A_RAND, m_rnd);
        chk("R4", {31'd0, timer_irq}, {31'd0, m_pend});
    endtask

    initial begin
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        // reset state
        rd("R1", A_TIME, 32'hFFFF_FFFF);
        rd("R3", A_CMP, 32'h0);
        rd("R6", A_RAND, 32'hB5C3_9A17);
        chk("R4", {31'd0, timer_irq}, 32'd0);

        // free running count and LFSR stepping
        for (int i = 0; i < 300; i++) begin tick(); look(); end

        // compare match raises sticky pending
        csr_addr = A_CMP; csr_wdata = m_time - 32'd12; csr_we = 1'b1;
        tick();
        rd("R3", A_CMP, m_cmp);
        chk("R5", {31'd0, timer_irq}, 32'd0);
        for (int i = 0; i < 25; i++) begin tick(); look(); end
        chk("R4", {31'd0, timer_irq}, 32'd1);

        // read-only writes ignored
        csr_addr = A_TIME; csr_wdata = 32'h0000_0005; csr_we = 1'b1;
        tick(); look(); rd("R2", A_TIME, m_time);
        csr_addr = A_RAND; csr_wdata = 32'h0; csr_we = 1'b1;
        tick(); look(); rd("R9", A_RAND, m_rnd);

        // compare write clears
        csr_addr = A_CMP; csr_wdata = 32'h0; csr_we = 1'b1;
        tick(); chk("R5", {31'd0, timer_irq}, 32'd0); look();

        // write colliding with a match: write wins
        csr_addr = A_CMP; csr_wdata = m_time - 32'd1; csr_we = 1'b1;
        tick(); look();
        csr_addr = A_CMP; csr_wdata = 32'h0; csr_we = 1'b1;
        tick(); chk("R5", {31'd0, timer_irq}, 32'd0);
        for (int i = 0; i < 4; i++) begin tick(); look(); end

        // unmapped addresses read zero, full 12-bit sweep
        for (int a = 0; a < 4096; a++) begin
            if (a == 'h7C0 || a == 'h7C1 || a == 'h7C2) rd("R11", 12'(a), (a == 'h7C1) ? m_cmp : ((a == 'h7C0) ? m_time : m_rnd));
            else rd("R10", 12'(a), 32'h0);
            if ((a % 4) == 3) tick();
        end

        // seed loads
        seed_ld = 1'b1; seed_val = 32'h1234_5678;
        tick(); rd("R7", A_RAND, 32'h1234_5678);
        seed_ld = 1'b1; seed_val = 32'h0;
        tick(); rd("R8", A_RAND, 32'h0000_0001);
        for (int i = 0; i < 100; i++) begin tick(); look(); end
        seed_ld = 1'b1; seed_val = 32'hDEAD_BEEF; csr_addr = A_RAND; csr_wdata = 32'h5; csr_we = 1'b1;
        tick(); rd("R7", A_RAND, 32'hDEAD_BEEF);
        for (int i = 0; i < 20; i++) begin tick(); look(); end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule